// File: doc/BRIEF.md
# Dual-Processor Mailbox Nibble and Doorbell Register

This block holds one 32-bit control/status word for each of two processors, called side A and side B. Each side owns a 4-bit message nibble that it writes in its own word. The same nibble appears, read-only, in the low bits of the other side's word. Each side has one plain write strobe with its write data. Each side also has an always-valid read view of its own word. There is no handshake: a write is taken on every clock edge where its strobe is high.

A write may also ring a doorbell toward the other side. When the write sets the ring bit, an interrupt pulse goes to the remote processor, but only if that processor has set its accept-enable bit. The pulse is combinational and lasts exactly the cycle of the write, so it suits an edge-sensitive input of an interrupt controller. The two sides are fully symmetric and work independently when they write in the same cycle.

Top module: `dsync_regs`

## Requirements
- R1: After reset, both read views are 0x0000_0000 and neither interrupt output is high.
- R2: A write on one side loads write-data bits 11:8 into its message nibble and bit 14 into its accept-enable bit. The new values appear in the read view from the clock edge that takes the write.
- R3: Write-data bits outside the mask 0x6F00 have no effect. Read-view bits 31:15, 12 and 7:4 always read 0.
- R4: Read-view bits 3:0 of each side always equal read-view bits 11:8 of the other side, in the same cycle.
- R5: Read-view bit 13 (the ring bit) always reads 0, because it is not stored.
- R6: In a cycle where side A writes with data bit 13 set, the output irq_to_b is high in that same cycle exactly when side B's stored accept-enable bit (the value before that edge) is 1. The same holds from B toward A through irq_to_a.
- R7: Without a write strobe, a side's stored fields do not change, and that side raises no doorbell. Write data presented without the strobe is ignored.
- R8: When both sides write in the same cycle, each side's field update and each doorbell are evaluated on their own. Both doorbells can fire together, and each one is gated by the enable that was stored before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_a | input | 1 | Side A write strobe |
| wr_data_a | input | 32 | Side A write data |
| rd_data_a | output | 32 | Side A register view |
| irq_to_a | output | 1 | Doorbell pulse delivered to side A |
| wr_en_b | input | 1 | Side B write strobe |
| wr_data_b | input | 32 | Side B write data |
| rd_data_b | output | 32 | Side B register view |
| irq_to_b | output | 1 | Doorbell pulse delivered to side B |

## Verification
Both sides can write in the same cycle. Each write can change its own accept-enable and also ring the other side, so a doorbell can be gated by an enable that is changing at that same edge. The vector table drives simultaneous writes twice. The first time, both enables are clear beforehand and are being set, so no pulse may appear. The second time, both enables are already set, so both pulses must appear together. Each pulse is sampled before the edge, and the read views are sampled after it.

// File: rtl/dsync_pkg.sv
package dsync_pkg;
  localparam int REG_W    = 32;
  localparam int NIB_W    = 4;
  localparam int IN_LSB   = 0;
  localparam int OUT_LSB  = 8;
  localparam int RING_BIT = 13;
  localparam int EN_BIT   = 14;
  localparam int SIDES    = 2;

  // Build the visible word from the stored fields and the mirrored nibble.
  function automatic logic [REG_W-1:0] build_view(
    input logic [NIB_W-1:0] in_nib,
    input logic [NIB_W-1:0] out_nib,
    input logic             accept_en
  );
    logic [REG_W-1:0] w;
    w = '0;
    w[IN_LSB  +: NIB_W] = in_nib;
    w[OUT_LSB +: NIB_W] = out_nib;
    w[EN_BIT]           = accept_en;
    return w;
  endfunction
endpackage

// File: rtl/dsync_side_reg.sv
module dsync_side_reg
  import dsync_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [NIB_W-1:0] out_nib,
  output logic             accept_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_nib   <= '0;
      accept_en <= 1'b0;
    end else if (wr_en) begin
      out_nib   <= wr_data[OUT_LSB +: NIB_W];
      accept_en <= wr_data[EN_BIT];
    end
  end

  // R2: a write lands in the stored fields at the next edge
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (out_nib == $past(wr_data[OUT_LSB +: NIB_W])) && (accept_en == $past(wr_data[EN_BIT])));

  // R7: no strobe, no change
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(out_nib) && $stable(accept_en));
endmodule

// File: rtl/dsync_doorbell.sv
module dsync_doorbell
  import dsync_pkg::*;
(
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             remote_accept,
  output logic             ring_pulse
);
  always_comb ring_pulse = wr_en && wr_data[RING_BIT] && remote_accept;
endmodule

// File: rtl/dsync_regs.sv
module dsync_regs
  import dsync_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en_a,
  input  logic [31:0] wr_data_a,
  output logic [31:0] rd_data_a,
  output logic        irq_to_a,
  input  logic        wr_en_b,
  input  logic [31:0] wr_data_b,
  output logic [31:0] rd_data_b,
  output logic        irq_to_b
);
  logic             wen  [SIDES];
  logic [REG_W-1:0] wdat [SIDES];
  logic [REG_W-1:0] view [SIDES];
  logic [NIB_W-1:0] nib  [SIDES];
  logic             acc  [SIDES];
  logic             ring [SIDES];

  always_comb begin
    wen[0]  = wr_en_a;
    wen[1]  = wr_en_b;
    wdat[0] = wr_data_a;
    wdat[1] = wr_data_b;
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    localparam int PEER = SIDES - 1 - s;

    dsync_side_reg u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wen[s]),
      .wr_data   (wdat[s]),
      .out_nib   (nib[s]),
      .accept_en (acc[s])
    );

    // ring[s]: doorbell delivered to side s, raised by the peer's write
    dsync_doorbell u_bell (
      .wr_en         (wen[PEER]),
      .wr_data       (wdat[PEER]),
      .remote_accept (acc[s]),
      .ring_pulse    (ring[s])
    );

    always_comb view[s] = build_view(nib[PEER], nib[s], acc[s]);
  end

  assign rd_data_a = view[0];
  assign rd_data_b = view[1];
  assign irq_to_a  = ring[0];
  assign irq_to_b  = ring[1];

  // R4: cross mirror between the two views
  a_r4_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_a[3:0] == rd_data_b[11:8]) && (rd_data_b[3:0] == rd_data_a[11:8]));

  // R6: a doorbell only reaches a side whose view shows its enable
  a_r6_gate_a: assert property (@(posedge clk) disable iff (!rst_n)
    irq_to_a |-> rd_data_a[14] && wr_en_b && wr_data_b[13]);
  a_r6_gate_b: assert property (@(posedge clk) disable iff (!rst_n)
    irq_to_b |-> rd_data_b[14] && wr_en_a && wr_data_a[13]);

  // R3/R5: unused and write-only bits read zero
  a_r3_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data_a & 32'hFFFF_B0F0) == 32'h0) && ((rd_data_b & 32'hFFFF_B0F0) == 32'h0));
endmodule

// File: tb/dsync_regs_tb_top.sv
module dsync_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_a = 1'b0, wr_en_b = 1'b0;
  logic [31:0] wr_data_a = '0, wr_data_b = '0;
  logic [31:0] rd_data_a, rd_data_b;
  logic        irq_to_a, irq_to_b;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dsync_regs dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en_a(wr_en_a), .wr_data_a(wr_data_a), .rd_data_a(rd_data_a), .irq_to_a(irq_to_a),
    .wr_en_b(wr_en_b), .wr_data_b(wr_data_b), .rd_data_b(rd_data_b), .irq_to_b(irq_to_b)
  );

  // {wa, da, wb, db, exp irq_to_a, exp irq_to_b, exp rd_a, exp rd_b}
  localparam int NV = 8;
  localparam logic [131:0] VEC [NV] = '{
    {1'b1, 32'h0000_4500, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_4500, 32'h0000_0005},
    {1'b0, 32'h0000_0000, 1'b1, 32'hFFFF_A3FF, 1'b1, 1'b0, 32'h0000_4503, 32'h0000_0305},
    {1'b1, 32'h0000_2C00, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0C03, 32'h0000_030C},
    {1'b1, 32'h0000_6A00, 1'b1, 32'h0000_6100, 1'b0, 1'b0, 32'h0000_4A01, 32'h0000_410A},
    {1'b1, 32'h0000_6700, 1'b1, 32'h0000_6200, 1'b1, 1'b1, 32'h0000_4702, 32'h0000_4207},
    {1'b0, 32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0000_4702, 32'h0000_4207},
    {1'b1, 32'h0000_BFFF, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 32'h0000_0F02, 32'h0000_420F},
    {1'b0, 32'h0000_0000, 1'b1, 32'h0000_2000, 1'b0, 1'b0, 32'h0000_0F00, 32'h0000_000F}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rd_a", rd_data_a, 32'h0);
    chk("R1 reset rd_b", rd_data_b, 32'h0);
    chk("R1 reset irqs", {30'd0, irq_to_a, irq_to_b}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {wr_en_a, wr_data_a, wr_en_b, wr_data_b} = VEC[i][131:66];
      #1;
      // R6 R8 doorbells in the write cycle
      chk($sformatf("R6/R8 vec%0d irq_to_a", i), {31'd0, irq_to_a}, {31'd0, VEC[i][65]});
      chk($sformatf("R6/R8 vec%0d irq_to_b", i), {31'd0, irq_to_b}, {31'd0, VEC[i][64]});
      @(posedge clk);
      #1;
      wr_en_a = 1'b0;
      wr_en_b = 1'b0;
      // R2 R3 R4 R5 R7 views after the edge
      chk($sformatf("R2/R3/R4/R5/R7 vec%0d rd_a", i), rd_data_a, VEC[i][63:32]);
      chk($sformatf("R2/R3/R4/R5/R7 vec%0d rd_b", i), rd_data_b, VEC[i][31:0]);
    end

    // R6: pulse lasts only the write cycle
    @(negedge clk);
    chk("R6 pulse ends", {30'd0, irq_to_a, irq_to_b}, 32'h0);

    // R5: ring bit alone stores nothing visible
    wr_en_a = 1'b1; wr_data_a = 32'h0000_2000;
    @(posedge clk); #1; wr_en_a = 1'b0;
    chk("R5 ring bit reads 0", rd_data_a, 32'h0000_0000);
    chk("R4 mirror cleared", rd_data_b, 32'h0000_0000);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    wr_en_b = 1'b1; wr_data_b = 32'h0000_4900;
    @(posedge clk); #1; wr_en_b = 1'b0;
    chk("R2 pre-reset load", rd_data_b, 32'h0000_4900);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset rd_a", rd_data_a, 32'h0);
    chk("R1 async reset rd_b", rd_data_b, 32'h0);
    finish_run();
  end
endmodule